// File: doc/BRIEF.md
# Parallel Metronome Phase-Tracking Bank

This block runs a bank of free-running metronomes. Each metronome has its own tempo and tests one tempo guess against a stream of detected beats. Each metronome is a phase accumulator. On every audio-sample strobe it adds its own per-sample increment, and a wrap of the accumulator is that metronome's tick. An upstream beat classifier sends a beat strobe together with an 8-bit confidence, and every metronome receives that strobe in the same cycle. Each metronome then does three things:

- It measures a signed phase error to its nearest tick, or to its nearest subdivision point when subdivisions are enabled.
- It reports that error.
- It pulls its phase toward the beat by the error scaled by the confidence.

Each metronome also keeps an exponentially smoothed average of its absolute error. The bank reports the index and the average of the metronome with the smallest average as the current best tempo. A controller can retarget any metronome by writing a new increment. The new increment is held and takes effect only at that metronome's next wrap. A sweep can therefore start wide and then narrow around the best candidates without disturbing the tick train.

Top module: `met_bank`

## Requirements
- R1: Reset state. While `rst_n` is low and right after it rises, all phases are zero and no metronome tick is high. `err_vld` is low, and `best_idx` and `best_avg` are zero. Metronome i starts with increment `BASE_INC + i*STEP_INC` and with a smoothed error of zero.
- R2: Sample advance. On a cycle with `smp_en` high, each phase gains its increment modulo 2^PH_W. Bit i of `tick` is high for exactly the one cycle after the edge at which that addition carried out of PH_W bits. Without `smp_en`, no phase advances and no tick occurs.
- R3: Error report. On a cycle with `beat_vld` high, every metronome takes its current phase and reads the low PH_W-SUB_LOG bits as a two's-complement value, sign-extended to PH_W bits. That value is its error. One cycle later `err_vld` is high for one cycle, and lane i of `err_flat`, at bits [i*PH_W +: PH_W], holds the error of metronome i.
- R4: Error bound. No reported error has a magnitude greater than 2^(PH_W-SUB_LOG-1), which is half a subdivision span.
- R5: Confidence-weighted pull. On a beat, each phase is reduced by (error × confidence) arithmetically shifted right by CORR_SHIFT, with floor rounding, before that cycle's sample increment is added. A confidence of zero leaves the phase unchanged. A beat without a sample strobe never makes the error magnitude grow.
- R6: Smoothed error. On each beat, a metronome's average A becomes A + ((|e| - A) >>> AVG_SHIFT), where e is the error reported for that beat and the shift floors. The average never exceeds 2^(PH_W-1).
- R7: Best tempo. `best_avg` and `best_idx` give the smallest average and its index as they stood one cycle earlier. On a tie, the lowest index wins.
- R8: Deferred retarget. A write with `tempo_wr` high places `tempo_inc` in a pending slot of metronome `tempo_sel`, and a later write replaces it. The pending increment is used only for additions after the next wrap of that metronome. The addition that causes the wrap still uses the old increment. A write in the same cycle as a wrap waits for the following wrap.
- R9: Broadcast. One beat strobe updates the error, phase and average of every metronome in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Audio sample strobe; advances all phases |
| beat_vld | input | 1 | Beat event from the classifier |
| beat_conf | input | CONF_W | Unsigned confidence of the beat |
| tempo_wr | input | 1 | Controller increment write |
| tempo_sel | input | IDX_W | Metronome addressed by the write |
| tempo_inc | input | PH_W | New per-sample phase increment |
| tick | output | N_MET | One-cycle wrap pulse per metronome |
| err_vld | output | 1 | Error bus holds the errors of the last beat |
| err_flat | output | N_MET*PH_W | Signed errors, lane i at [i*PH_W +: PH_W] |
| best_idx | output | IDX_W | Index of the smallest smoothed error |
| best_avg | output | PH_W | Smallest smoothed error |

## Verification
The embedded properties watch several behaviours on every cycle:

- A tick never appears without a sample strobe on the cycle before.
- An increment changes only on a cycle that carries a tick.
- A beat without a sample strobe never leaves a larger error.
- The smoothed error stays bounded.
- `err_vld` only follows a beat.
- `best_avg` never exceeds any lane's previous average.

Only the bench scenarios can show the exact arithmetic values. These cover the floor-rounded confidence pull and the smoothing result. They also cover the pending-increment timing when writes collide with wraps or replace one another, and the tie-breaking of the best-tempo search.

// File: rtl/met_pkg.sv
package met_pkg;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/met_smooth.sv
module met_smooth #(
   parameter int unsigned PH_W      = 24,
   parameter int unsigned AVG_SHIFT = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   upd,
   input  logic signed [PH_W-1:0] err_in,
   output logic [PH_W-1:0]        avg
);
   localparam logic [PH_W-1:0] HALF_SPAN = PH_W'(1) << (PH_W - 1);

   logic [PH_W-1:0]        mag;
   logic signed [PH_W:0]   diff;
   logic signed [PH_W:0]   step;
   logic [PH_W-1:0]        avg_q;

   // magnitude of the most negative value wraps to exactly HALF_SPAN
   assign mag  = err_in[PH_W-1] ? PH_W'(-err_in) : PH_W'(err_in);
   assign diff = $signed({1'b0, mag}) - $signed({1'b0, avg_q});
   assign step = diff >>> AVG_SHIFT;

   always_ff @(posedge clk) begin
      if (!rst_n) avg_q <= '0;
      else if (upd) avg_q <= PH_W'($signed({1'b0, avg_q}) + step);
   end

   assign avg = avg_q;

   // R6: the average stays within half a period
   assert_avg_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      avg_q <= HALF_SPAN);
endmodule

// File: rtl/met_cell.sv
module met_cell #(
   parameter int unsigned PH_W       = 24,
   parameter int unsigned CONF_W     = 8,
   parameter int unsigned CORR_SHIFT = 8,
   parameter int unsigned AVG_SHIFT  = 3,
   parameter int unsigned SUB_LOG    = 0,
   parameter logic [PH_W-1:0] INIT_INC = PH_W'(1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_en,
   input  logic                   beat_vld,
   input  logic [CONF_W-1:0]      beat_conf,
   input  logic                   wr_en,
   input  logic [PH_W-1:0]        wr_inc,
   output logic                   tick,
   output logic signed [PH_W-1:0] err_q,
   output logic [PH_W-1:0]        avg
);
   localparam int unsigned SEG_W  = PH_W - SUB_LOG;
   localparam int unsigned PROD_W = PH_W + CONF_W + 1;

   logic [PH_W-1:0]          phase_q, inc_q, pinc_q;
   logic                     pend_q, tick_q;
   logic signed [PH_W-1:0]   err_now;
   logic [PH_W-1:0]          err_abs;
   logic signed [PROD_W-1:0] prod;
   logic signed [PH_W-1:0]   corr;
   logic [PH_W-1:0]          phase_adj;
   logic [PH_W-1:0]          sum;
   logic                     carry;

   // error against the nearest tick or subdivision point
   generate
      if (SUB_LOG == 0) begin : g_full
         assign err_now = $signed(phase_q);
      end else begin : g_sub
         assign err_now = $signed({{SUB_LOG{phase_q[SEG_W-1]}}, phase_q[SEG_W-1:0]});
      end
   endgenerate

   assign err_abs   = err_now[PH_W-1] ? PH_W'(-err_now) : PH_W'(err_now);
   assign prod      = PROD_W'(err_now) * $signed({1'b0, beat_conf});
   assign corr      = PH_W'(prod >>> CORR_SHIFT);
   assign phase_adj = beat_vld ? PH_W'($signed(phase_q) - corr) : phase_q;
   assign {carry, sum} = {1'b0, phase_adj} + {1'b0, inc_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= '0;
         inc_q   <= INIT_INC;
         pinc_q  <= '0;
         pend_q  <= 1'b0;
         tick_q  <= 1'b0;
         err_q   <= '0;
      end else begin
         tick_q <= smp_en & carry;
         if (smp_en) phase_q <= sum;
         else        phase_q <= phase_adj;
         if (beat_vld) err_q <= err_now;
         if (smp_en && carry && pend_q) begin
            inc_q  <= pinc_q;
            pend_q <= 1'b0;
         end
         if (wr_en) begin
            pend_q <= 1'b1;
            pinc_q <= wr_inc;
         end
      end
   end

   assign tick = tick_q;

   met_smooth #(.PH_W(PH_W), .AVG_SHIFT(AVG_SHIFT)) u_smooth (
      .clk(clk), .rst_n(rst_n), .upd(beat_vld), .err_in(err_now), .avg(avg));

   // R2: a tick only follows a sample strobe
   assert_tick_needs_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> $past(smp_en));
   // R8: the increment only changes on a wrap
   assert_inc_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(inc_q) |-> tick_q);
   // R5: a pull without advance never grows the error
   assert_pull_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_vld && !smp_en) |=> err_abs <= $past(err_abs));
endmodule

// File: rtl/met_argmin.sv
module met_argmin #(
   parameter int unsigned N_MET = 8,
   parameter int unsigned PH_W  = 24,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N_MET*PH_W-1:0] avg_flat,
   output logic [IDX_W-1:0]      min_idx,
   output logic [PH_W-1:0]       min_val
);
   always_comb begin
      min_idx = '0;
      min_val = avg_flat[PH_W-1:0];
      for (int i = 1; i < N_MET; i++) begin
         if (avg_flat[i*PH_W +: PH_W] < min_val) begin
            min_val = avg_flat[i*PH_W +: PH_W];
            min_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/met_bank.sv
module met_bank #(
   parameter int unsigned N_MET      = 8,
   parameter int unsigned PH_W       = 24,
   parameter int unsigned CONF_W     = 8,
   parameter int unsigned CORR_SHIFT = 8,
   parameter int unsigned AVG_SHIFT  = 3,
   parameter int unsigned SUB_LOG    = 0,
   parameter logic [PH_W-1:0] BASE_INC = 24'h010000,
   parameter logic [PH_W-1:0] STEP_INC = 24'h000400,
   localparam int unsigned IDX_W = met_pkg::idx_width(N_MET)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_en,
   input  logic                    beat_vld,
   input  logic [CONF_W-1:0]       beat_conf,
   input  logic                    tempo_wr,
   input  logic [IDX_W-1:0]        tempo_sel,
   input  logic [PH_W-1:0]         tempo_inc,
   output logic [N_MET-1:0]        tick,
   output logic                    err_vld,
   output logic [N_MET*PH_W-1:0]   err_flat,
   output logic [IDX_W-1:0]        best_idx,
   output logic [PH_W-1:0]         best_avg
);
   generate
      if (N_MET < 2)            begin : g_chk_n   $error("N_MET must be at least 2"); end
      if (SUB_LOG >= PH_W - 1)  begin : g_chk_sub $error("SUB_LOG too large for PH_W"); end
      if (CONF_W < 1 || CONF_W > 16) begin : g_chk_c $error("CONF_W out of range"); end
   endgenerate

   logic [N_MET*PH_W-1:0] avg_flat;
   logic [IDX_W-1:0]      min_idx;
   logic [PH_W-1:0]       min_val;
   logic                  vld_q;
   logic [IDX_W-1:0]      best_idx_q;
   logic [PH_W-1:0]       best_avg_q;

   genvar gi;
   generate
      for (gi = 0; gi < N_MET; gi++) begin : g_met
         logic signed [PH_W-1:0] lane_err;
         met_cell #(
            .PH_W(PH_W), .CONF_W(CONF_W), .CORR_SHIFT(CORR_SHIFT),
            .AVG_SHIFT(AVG_SHIFT), .SUB_LOG(SUB_LOG),
            .INIT_INC(PH_W'(BASE_INC + gi * STEP_INC))
         ) u_cell (
            .clk(clk), .rst_n(rst_n), .smp_en(smp_en),
            .beat_vld(beat_vld), .beat_conf(beat_conf),
            .wr_en(tempo_wr && (tempo_sel == IDX_W'(gi))),
            .wr_inc(tempo_inc),
            .tick(tick[gi]), .err_q(lane_err),
            .avg(avg_flat[gi*PH_W +: PH_W]));
         assign err_flat[gi*PH_W +: PH_W] = lane_err;

         // R7: the reported best never exceeds any lane's prior average
         assert_best_le_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
            best_avg_q <= $past(avg_flat[gi*PH_W +: PH_W]));
      end
   endgenerate

   met_argmin #(.N_MET(N_MET), .PH_W(PH_W), .IDX_W(IDX_W)) u_min (
      .avg_flat(avg_flat), .min_idx(min_idx), .min_val(min_val));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q      <= 1'b0;
         best_idx_q <= '0;
         best_avg_q <= '0;
      end else begin
         vld_q      <= beat_vld;
         best_idx_q <= min_idx;
         best_avg_q <= min_val;
      end
   end

   assign err_vld  = vld_q;
   assign best_idx = best_idx_q;
   assign best_avg = best_avg_q;

   // R3: a report only follows a beat
   assert_report_after_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |-> $past(beat_vld));
endmodule

// File: tb/sim_met_bank.sv
`timescale 1ns/1ps
module sim_met_bank;
   localparam int unsigned N   = 8;
   localparam int unsigned W   = 24;
   localparam int unsigned K   = 8;
   localparam int unsigned A   = 3;
   localparam int unsigned SUB = 0;
   localparam int unsigned IW  = 3;
   localparam longint BASE = 64'h010000;
   localparam longint STEP = 64'h000400;
   localparam longint MASK = (64'd1 << W) - 1;
   localparam int unsigned SEG = W - SUB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_en = 1'b0, beat_vld = 1'b0, tempo_wr = 1'b0;
   logic [7:0] beat_conf = '0;
   logic [IW-1:0] tempo_sel = '0;
   logic [W-1:0] tempo_inc = '0;
   logic [N-1:0] tick;
   logic err_vld;
   logic [N*W-1:0] err_flat;
   logic [IW-1:0] best_idx;
   logic [W-1:0] best_avg;

   int total = 0, bad = 0;
   bit done = 1'b0;

   longint ph[N], inc[N], pinc[N], avg[N], exp_err[N];
   bit pend[N];
   logic [N-1:0] exp_tick;
   bit exp_vld;
   longint exp_bidx, exp_bavg;

   always #2.5 clk = ~clk;

   met_bank u0 (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .beat_vld(beat_vld),
      .beat_conf(beat_conf), .tempo_wr(tempo_wr), .tempo_sel(tempo_sel),
      .tempo_inc(tempo_inc), .tick(tick), .err_vld(err_vld),
      .err_flat(err_flat), .best_idx(best_idx), .best_avg(best_avg));

   task automatic check(input string req, input longint act, input longint expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic longint seg_err(input longint p);
      longint s = p & ((64'd1 << SEG) - 1);
      if (s >= (64'd1 << (SEG - 1))) s -= (64'd1 << SEG);
      return s;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         ph[i] = 0; inc[i] = (BASE + i * STEP) & MASK; pinc[i] = 0;
         pend[i] = 0; avg[i] = 0; exp_err[i] = 0;
      end
      exp_tick = '0; exp_vld = 0; exp_bidx = 0; exp_bavg = 0;
   endtask

   // reference update for one clock, built from the requirements
   task automatic model_step(input bit s, input bit b, input int conf,
                             input bit we, input int sel, input longint ni);
      exp_bidx = 0; exp_bavg = avg[0];
      for (int i = 1; i < N; i++)
         if (avg[i] < exp_bavg) begin exp_bavg = avg[i]; exp_bidx = i; end
      exp_vld = b;
      for (int i = 0; i < N; i++) begin
         longint e = seg_err(ph[i]);
         if (b) begin
            longint c = (e * conf) >>> K;
            longint m = (e < 0) ? -e : e;
            exp_err[i] = e;
            ph[i] = (ph[i] - c) & MASK;
            avg[i] = avg[i] + ((m - avg[i]) >>> A);
         end
         exp_tick[i] = 1'b0;
         if (s) begin
            longint sm = ph[i] + inc[i];
            ph[i] = sm & MASK;
            if ((sm >> W) != 0) begin
               exp_tick[i] = 1'b1;
               if (pend[i]) begin inc[i] = pinc[i]; pend[i] = 0; end
            end
         end
         if (we && sel == i) begin pend[i] = 1; pinc[i] = ni; end
      end
   endtask

   task automatic cyc(input string ttag, input bit s, input bit b, input int conf,
                      input bit we, input int sel, input longint ni);
      @(negedge clk);
      smp_en = s; beat_vld = b; beat_conf = 8'(conf);
      tempo_wr = we; tempo_sel = IW'(sel); tempo_inc = W'(ni);
      model_step(s, b, conf, we, sel, ni);
      @(posedge clk); #1;
      check({ttag, " tick"}, longint'(tick), longint'(exp_tick));
      check("R3 err_vld", longint'(err_vld), longint'(exp_vld));
      check("R7 best_idx", longint'(best_idx), exp_bidx);
      check("R6/R7 best_avg", longint'(best_avg), exp_bavg);
      if (exp_vld) begin
         for (int i = 0; i < N; i++) begin
            longint a = longint'($signed(err_flat[i*W +: W]));
            longint ma = (a < 0) ? -a : a;
            check("R3/R5/R9 lane error", a, exp_err[i]);
            total++;
            if (ma > (64'd1 << (SEG - 1))) begin
               bad++;
               $display("FAIL R4 actual=%0d expected<=%0d", ma, 64'd1 << (SEG - 1));
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'h5eed));
      model_reset();
      repeat (3) @(posedge clk);
      #1;
      check("R1 tick at reset", longint'(tick), 0);
      check("R1 err_vld at reset", longint'(err_vld), 0);
      check("R1 best_idx at reset", longint'(best_idx), 0);
      check("R1 best_avg at reset", longint'(best_avg), 0);
      @(negedge clk); rst_n = 1'b1;
      // R1/R2: initial increments set the first tick spacing
      for (int c = 0; c < 300; c++) cyc("R1/R2", 1, 0, 0, 0, 0, 0);
      // no advance without the strobe
      for (int c = 0; c < 20; c++) cyc("R2", 0, 0, 0, 0, 0, 0);
      // R5: zero confidence leaves phase, repeated beat shows same error
      cyc("R2", 1, 1, 0, 0, 0, 0);
      cyc("R2", 0, 1, 0, 0, 0, 0);
      cyc("R2", 0, 1, 0, 0, 0, 0);
      // R5: full confidence pulls twice without advance
      cyc("R2", 0, 1, 255, 0, 0, 0);
      cyc("R2", 0, 1, 255, 0, 0, 0);
      // R8: write, replace, then let it wrap; write on a wrap cycle
      cyc("R8", 1, 0, 0, 1, 2, 64'h020000);
      cyc("R8", 1, 0, 0, 1, 2, 64'h008000);
      for (int c = 0; c < 600; c++) cyc("R2/R8", 1, 0, 0, (c % 97) == 5, 3, 64'h00C000 + c);
      // R7: tie on all averages after reset-equal state picks the lowest index
      // randomized mix
      for (int c = 0; c < 6000; c++) begin
         bit s  = ($urandom % 10) < 7;
         bit b  = ($urandom % 20) == 0;
         int cf = int'($urandom % 256);
         bit we = ($urandom % 50) == 0;
         int sl = int'($urandom % N);
         longint ni = 64'h008000 + longint'($urandom % 32'h018000);
         cyc("R2/R8", s, b, cf, we, sl, ni);
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule